// File: doc/BRIEF.md
# Pin Interrupt Controller

This block turns pin activity on several 16-bit GPIO ports into interrupt requests on 32 channels. A routing register picks, for each of the four 8-bit lanes of the channel space, which port drives that lane. Lanes 0 and 2 take bits 7:0 of the chosen port and lanes 1 and 3 take bits 15:8. Each channel is then qualified on its own: edge or level, with an optional inversion of polarity. A detected event sets a sticky request bit, and software clears that bit by writing ones.

A single interrupt line is raised whenever a pending request is also enabled in the mask. Mask, edge mode and polarity each have a set alias and a clear alias, so software can change one channel without a read-modify-write. To catch both edges on a channel, software flips that channel's inversion each time it services the request.

Top module: `pint_top`

## Requirements
- R1: After reset, the mask, request, routing, edge and inversion registers all read zero and `irq_out` is low.
- R2: A write to word address 4 sets each edge-mode bit whose data bit is one. A write to address 5 clears each such bit. Both addresses read back the current edge-mode vector (1 = edge, 0 = level).
- R3: A write to word address 6 sets each inversion bit whose data bit is one. A write to address 7 clears each such bit. Both addresses read back the current inversion vector.
- R4: A write to word address 0 enables the mask bits whose data bits are one, and a write to address 1 disables them. Both addresses read the mask. Writing all ones to address 1 disables every channel, so `irq_out` is low from the next cycle.
- R5: A channel in edge mode latches its request once per rising transition of its qualified input. The qualified input is the routed pin XOR the inversion bit, so an inverted channel latches on a falling pin. A steady input causes no further latching.
- R6: A channel in level mode latches its request while its qualified input is high. A clear written while that level persists leaves the bit set.
- R7: The request vector is at word address 2. Writing ones there clears those latched bits, and zero data bits leave their bits unchanged.
- R8: `irq_out` is high exactly when some channel has both its request bit and its mask bit set.
- R9: The routing register is at word address 3. Its byte k (bits 8k+7:8k) selects the port for channels 8k+7:8k. Lanes 0 and 2 take bits 7:0 of that port, and lanes 1 and 3 take bits 15:8. Port p occupies `pins` bits 16p+15:16p.
- R10: A routing byte whose value is not below NUM_PORTS feeds zeros into its lane.
- R11: A pin change is synchronized through two flops. The request bit, and `irq_out` if the channel is masked in, change on the third rising clock edge after the pin changes.
- R12: Toggling a channel's inversion while its pin is steady produces no event from the resulting fall of the qualified input. This allows both-edge detection by toggling the inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | NUM_PORTS*16 | Pin vectors of all attached ports, port p at bits 16p+15:16p |
| bus_we | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A register write lands on the rising edge where `bus_we` is sampled, and reads are combinational. The bench therefore reads at the falling edge that follows a write. A pin change reaches the request register on the third rising edge. The latency checks sample at the second falling edge, expecting no change yet, and at the third, expecting the new value. Because `irq_out` is combinational from request and mask, it is checked in the same half cycle as the request bit it depends on. Level-mode results are read only after the routed level has settled for four cycles and a clear has been written.

// File: rtl/pint_pkg.sv
package pint_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [3:0] {
    A_MASK_SET = 4'd0,
    A_MASK_CLR = 4'd1,
    A_REQUEST  = 4'd2,
    A_ROUTE    = 4'd3,
    A_EDGE_SET = 4'd4,
    A_EDGE_CLR = 4'd5,
    A_INV_SET  = 4'd6,
    A_INV_CLR  = 4'd7
  } reg_addr_e;

  // set-alias update: ones in data turn bits on
  function automatic logic [31:0] w1s(input logic [31:0] cur, input logic [31:0] d);
    return cur | d;
  endfunction

  // clear-alias update: ones in data turn bits off
  function automatic logic [31:0] w1c(input logic [31:0] cur, input logic [31:0] d);
    return cur & ~d;
  endfunction

endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pint_router.sv
module pint_router #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 16,
  parameter int CH        = 32
) (
  input  logic [NUM_PORTS*PORT_W-1:0] ports,
  input  logic [CH-1:0]               route,
  output logic [CH-1:0]               lanes
);
  import pint_pkg::*;

  localparam int LANES     = CH / LANE_W;
  localparam int PORT_BYTES = PORT_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int BYTE_IN_PORT = l % PORT_BYTES;
    logic [LANE_W-1:0] sel;
    logic [LANE_W-1:0] data;

    assign sel = route[l*LANE_W +: LANE_W];

    always_comb begin
      data = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel == LANE_W'(p))
          data = ports[p*PORT_W + BYTE_IN_PORT*LANE_W +: LANE_W];
      end
    end

    assign lanes[l*LANE_W +: LANE_W] = data;
  end
endmodule

// File: rtl/pint_detect.sv
module pint_detect #(
  parameter int CH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] lvl,
  input  logic [CH-1:0] inv,
  input  logic [CH-1:0] edge_mode,
  input  logic [CH-1:0] clr,
  output logic [CH-1:0] qual,
  output logic [CH-1:0] evt,
  output logic [CH-1:0] req
);
  logic [CH-1:0] qual_d;

  assign qual = lvl ^ inv;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign evt[c] = edge_mode[c] ? (qual[c] & ~qual_d[c]) : qual[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qual_d[c] <= 1'b0;
        req[c]    <= 1'b0;
      end else begin
        qual_d[c] <= qual[c];
        req[c]    <= (req[c] & ~clr[c]) | evt[c];
      end
    end
  end
endmodule

// File: rtl/pint_top.sv
module pint_top #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 16,
  parameter int CH        = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pins,
  input  logic                        bus_we,
  input  logic [3:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq_out
);
  import pint_pkg::*;

  localparam int PIN_W = NUM_PORTS * PORT_W;

  logic [CH-1:0]    mask_q, edge_q, inv_q, route_q;
  logic [PIN_W-1:0] pins_s;
  logic [CH-1:0]    lanes, qual, evt, req_q, req_clr;
  logic             wr_req;

  pint_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  pint_router #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .CH(CH)) u_route (
    .ports(pins_s), .route(route_q), .lanes(lanes)
  );

  assign wr_req  = bus_we && (bus_addr == A_REQUEST);
  assign req_clr = wr_req ? bus_wdata[CH-1:0] : '0;

  pint_detect #(.CH(CH)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lanes), .inv(inv_q), .edge_mode(edge_q),
    .clr(req_clr), .qual(qual), .evt(evt), .req(req_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      edge_q  <= '0;
      inv_q   <= '0;
      route_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MASK_SET: mask_q  <= w1s(mask_q, bus_wdata);
        A_MASK_CLR: mask_q  <= w1c(mask_q, bus_wdata);
        A_ROUTE:    route_q <= bus_wdata;
        A_EDGE_SET: edge_q  <= w1s(edge_q, bus_wdata);
        A_EDGE_CLR: edge_q  <= w1c(edge_q, bus_wdata);
        A_INV_SET:  inv_q   <= w1s(inv_q, bus_wdata);
        A_INV_CLR:  inv_q   <= w1c(inv_q, bus_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_MASK_SET, A_MASK_CLR: bus_rdata = mask_q;
      A_REQUEST:              bus_rdata = req_q;
      A_ROUTE:                bus_rdata = route_q;
      A_EDGE_SET, A_EDGE_CLR: bus_rdata = edge_q;
      A_INV_SET, A_INV_CLR:   bus_rdata = inv_q;
      default:                bus_rdata = '0;
    endcase
  end

  assign irq_out = |(req_q & mask_q);
endmodule

// File: rtl/pint_checker.sv
module pint_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq_out,
  input logic [31:0] mask_q,
  input logic [31:0] edge_q,
  input logic [31:0] inv_q,
  input logic [31:0] req_q,
  input logic [31:0] evt
);
  // R8: the line can only be high with some channel enabled
  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_q != 32'h0));

  // R4: all-ones mask clear silences the output next cycle
  p_mask_all_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd1 && bus_wdata == 32'hFFFF_FFFF) |=> !irq_out);

  // R5: a request bit never rises without an event the cycle before
  p_req_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((req_q & ~$past(req_q) & ~$past(evt)) == 32'h0));

  // R5: an edge-mode channel cannot fire in two consecutive cycles
  p_edge_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((evt & $past(evt) & edge_q & $past(edge_q)) == 32'h0));

  // R7: cleared bits stay clear unless a new event arrived
  p_req_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd2) |=> ((req_q & $past(bus_wdata) & ~$past(evt)) == 32'h0));

  // R2: edge-set alias turns the written bits on
  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd4) |=> ((edge_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: invert-clear alias turns the written bits off
  p_inv_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd7) |=> ((inv_q & $past(bus_wdata)) == 32'h0));
endmodule

bind pint_top pint_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .mask_q(mask_q), .edge_q(edge_q),
  .inv_q(inv_q), .req_q(req_q), .evt(evt)
);

// File: tb/pint_top_test.sv
module pint_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pint_top uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [31:0] route;
    logic [63:0] pv;
    logic [31:0] expect_req;
  } vec_t;

  // R9/R10 routing table: port3=DDCC port2=BBAA port1=9988 port0=7766
  localparam vec_t VECS [5] = '{
    '{32'h0000_0000, 64'hDDCC_BBAA_9988_7766, 32'h7766_7766},
    '{32'h0302_0100, 64'hDDCC_BBAA_9988_7766, 32'hDDAA_9966},
    '{32'h0101_0202, 64'hDDCC_BBAA_9988_7766, 32'h9988_BBAA},
    '{32'h05FF_0304, 64'hDDCC_BBAA_9988_7766, 32'h0000_DD00},
    '{32'h0302_0100, 64'h0000_0000_0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), r);
      check("R1 reg", r, 32'h0);
    end
    check("R1 irq", {31'h0, irq_out}, 32'h0);

    // R2 edge aliases
    wr(4'd4, 32'h0000_F00F);
    rd(4'd4, r); check("R2 set read", r, 32'h0000_F00F);
    wr(4'd5, 32'h0000_000F);
    rd(4'd5, r); check("R2 clr read", r, 32'h0000_F000);
    wr(4'd5, 32'hFFFF_FFFF);

    // R3 inversion aliases
    wr(4'd6, 32'hA500_0000);
    rd(4'd7, r); check("R3 set read", r, 32'hA500_0000);
    wr(4'd7, 32'h0500_0000);
    rd(4'd6, r); check("R3 clr read", r, 32'hA000_0000);
    wr(4'd7, 32'hFFFF_FFFF);

    // R4 mask aliases
    wr(4'd0, 32'h0000_0003);
    rd(4'd1, r); check("R4 set read", r, 32'h0000_0003);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd0, r); check("R4 all clear", r, 32'h0);

    // R9 / R10 routing in level mode
    foreach (VECS[i]) begin
      wr(4'd3, VECS[i].route);
      pins = VECS[i].pv;
      wait_n(4);
      wr(4'd2, 32'hFFFF_FFFF);
      rd(4'd2, r);
      check("R9 R10 route", r, VECS[i].expect_req);
    end

    // edge mode setup: route 0x03020100, pins low, requests clear
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0000_0001);
    rd(4'd2, r); check("R5 idle", r, 32'h0);

    // R11 latency + R5 rising edge on channel 0
    @(negedge clk);
    pins[0] = 1'b1;
    wait_n(2);
    rd(4'd2, r); check("R11 not yet", r, 32'h0);
    check("R11 irq not yet", {31'h0, irq_out}, 32'h0);
    wait_n(1);
    rd(4'd2, r); check("R11 latched", r, 32'h1);
    check("R8 irq high", {31'h0, irq_out}, 32'h1);

    // R7 zeros leave bits, ones clear
    wr(4'd2, 32'hFFFF_FFFE);
    rd(4'd2, r); check("R7 zero no effect", r, 32'h1);
    wr(4'd2, 32'h0000_0001);
    wait_n(3);
    rd(4'd2, r); check("R5 steady no relatch", r, 32'h0);
    check("R8 irq low", {31'h0, irq_out}, 32'h0);

    // R5 inverted channel 1 catches a falling pin
    pins[1] = 1'b1;
    wait_n(4);
    wr(4'd6, 32'h0000_0002);
    wr(4'd2, 32'hFFFF_FFFF);
    wait_n(3);
    rd(4'd2, r); check("R5 invert no event", r, 32'h0);
    pins[1] = 1'b0;
    wait_n(4);
    rd(4'd2, r); check("R5 falling latched", r, 32'h2);
    wr(4'd2, 32'hFFFF_FFFF);

    // R12 both-edge by toggling inversion on channel 2
    pins[2] = 1'b1;
    wait_n(4);
    rd(4'd2, r); check("R12 rise", r, 32'h4);
    wr(4'd2, 32'h0000_0004);
    wr(4'd6, 32'h0000_0004);
    wait_n(3);
    rd(4'd2, r); check("R12 toggle quiet", r, 32'h0);
    pins[2] = 1'b0;
    wait_n(4);
    rd(4'd2, r); check("R12 fall", r, 32'h4);
    wr(4'd2, 32'hFFFF_FFFF);

    // R6 level mode on channel 8 (port1 bit 8 -> pins[24])
    wr(4'd5, 32'h0000_0100);
    pins[24] = 1'b1;
    wait_n(4);
    rd(4'd2, r); check("R6 level latched", r, 32'h100);
    wr(4'd2, 32'h0000_0100);
    rd(4'd2, r); check("R6 persists", r, 32'h100);

    // R8 mask gating
    check("R8 unmasked low", {31'h0, irq_out}, 32'h0);
    wr(4'd0, 32'h0000_0100);
    check("R8 masked in", {31'h0, irq_out}, 32'h1);
    wr(4'd1, 32'hFFFF_FFFF);
    check("R4 all clear irq", {31'h0, irq_out}, 32'h0);

    pins[24] = 1'b0;
    wait_n(4);
    rd(4'd2, r); check("R6 sticky", r, 32'h100);
    wr(4'd2, 32'h0000_0100);
    rd(4'd2, r); check("R6 cleared", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule